// File: doc/BRIEF.md
# Truncating Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words in the common single-precision layout. It is purely combinational. Each operand is split into a sign, an 8-bit biased exponent and a 23-bit fraction, and the hidden leading one is put back to form a 24-bit significand. The two significands are multiplied by a radix-4 Booth recoded array. The partial products are summed by a chain of ripple-carry adders. Next the exponents are added and the bias is removed, and the 48-bit product is normalized. Finally the result is packed. Low-order product bits are dropped, and no rounding is done, so the output can feed an accumulator without a rounding error being added at this stage.

The block detects results whose exponent falls out of range. On overflow it returns a signed infinity and raises its own flag. On underflow it returns a signed zero and raises its own flag. An operand whose exponent field is zero is treated as zero. Infinities, NaNs and denormal inputs are not handled specially.

Top module: `fpm_mul_top`

## Requirements
- R1: A normal result carries a fraction equal to the 23 bits that follow the leading one of the exact 48-bit significand product.
- R2: The result sign (bit 31) is the XOR of the two operand signs, for every input, including the zero, overflow and underflow outputs.
- R3: The result exponent field (bits 30:23) equals exp_a + exp_b - 127, plus one when the product is normalized by a shift.
- R4: When bit 47 of the significand product is set, the product is shifted right by one place before the fraction is taken. Otherwise bits 45:23 form the fraction.
- R5: No rounding is applied; the discarded low bits never change the result (0x3FFFFFFF squared gives 0x407FFFFE).
- R6: If the adjusted biased exponent is 255 or more, ovf_o is 1, unf_o is 0, and y_o is signed infinity (exponent field 0xFF, fraction 0).
- R7: If the adjusted biased exponent is 0 or less, unf_o is 1, ovf_o is 0, and y_o is signed zero (exponent and fraction fields 0).
- R8: If either operand has a zero exponent field, y_o is signed zero and both flags are 0.
- R9: The significand product is exact for all 24-bit significands, including all-ones and alternating fraction patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand word |
| b_i | input | 32 | Second operand word |
| y_o | output | 32 | Packed, truncated product |
| ovf_o | output | 1 | Result exponent above the normal range |
| unf_o | output | 1 | Result exponent below the normal range |

## Verification
The normalization increment and the range checks can act on the same operand pair. A product of two large significands carries into bit 47 and lifts the exponent by one, which can turn a result that fits into an overflow or an underflow into a normal number. The bench provokes this with stored exponents that sum to exactly 254 + 127 with 1.5 × 1.5, and to exactly 127 with the same significands. It also runs the same exponent sums without the carry. Each outcome is judged against a model built from an exact integer product of the significands.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int EXT_W   = EXP_W + 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              is_zero;
    } fp_parts_t;

    typedef enum logic [2:0] {
        BD_ZERO,
        BD_POS1,
        BD_POS2,
        BD_NEG1,
        BD_NEG2
    } booth_digit_t;

    function automatic booth_digit_t booth_encode(input logic [2:0] grp);
        booth_digit_t d;
        case (grp)
            3'b001, 3'b010: d = BD_POS1;
            3'b011:         d = BD_POS2;
            3'b100:         d = BD_NEG2;
            3'b101, 3'b110: d = BD_NEG1;
            default:        d = BD_ZERO;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fp_parts_t         parts_o
);
    fp_word_t w;
    assign w = fp_word_t'(word_i);

    always_comb begin
        parts_o.sign    = w.sign;
        parts_o.exp     = w.exp;
        parts_o.is_zero = (w.exp == '0);
        parts_o.sig     = {~parts_o.is_zero, w.frac};
    end
endmodule

// File: rtl/fpm_rca.sv
module fpm_rca #(
    parameter int W = 48
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);
    logic [W:0] c;
    assign c[0] = cin_i;

    for (genvar k = 0; k < W; k++) begin : g_fa
        assign sum_o[k] = x_i[k] ^ y_i[k] ^ c[k];
        assign c[k+1]   = (x_i[k] & y_i[k]) | (c[k] & (x_i[k] ^ y_i[k]));
    end

    logic unused_carry;
    assign unused_carry = c[W];
endmodule

// File: rtl/fpm_booth_mult.sv
module fpm_booth_mult
    import fpm_pkg::*;
#(
    parameter int W = SIG_W
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] p_o
);
    localparam int NDIG = W / 2 + 1;
    localparam int BW   = 2 * NDIG;
    localparam int PW   = 2 * W;

    logic [BW:0] ext;
    assign ext = {{(BW - W){1'b0}}, b_i, 1'b0};

    logic [PW-1:0] pp  [NDIG];
    logic          neg [NDIG];
    logic [PW-1:0] acc [NDIG+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        booth_digit_t  dig;
        logic [W:0]    mag;
        logic [PW-1:0] shifted;

        assign dig = booth_encode(ext[2*i+2 -: 3]);

        always_comb begin
            case (dig)
                BD_POS1, BD_NEG1: mag = {1'b0, a_i};
                BD_POS2, BD_NEG2: mag = {a_i, 1'b0};
                default:          mag = '0;
            endcase
        end

        assign shifted = PW'(mag) << (2 * i);
        assign neg[i]  = (dig == BD_NEG1) || (dig == BD_NEG2);
        assign pp[i]   = neg[i] ? ~shifted : shifted;

        fpm_rca #(.W(PW)) u_add (
            .x_i   (acc[i]),
            .y_i   (pp[i]),
            .cin_i (neg[i]),
            .sum_o (acc[i+1])
        );
    end

    assign p_o = acc[NDIG];

    always_comb begin
        if (a_i[W-1] && b_i[W-1]) begin
            p_norm_range_r4: assert (p_o[PW-1:PW-2] != 2'b00)
                else $error("product of normal significands lost its leading one");
        end
        if (a_i == '0 || b_i == '0) begin
            p_zero_prod_r9: assert (p_o == '0)
                else $error("zero significand gave nonzero product");
        end
    end
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
    import fpm_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_a_i,
    input  logic [EXP_W-1:0]  exp_b_i,
    input  logic              zero_in_i,
    input  logic [PROD_W-1:0] prod_i,
    output logic [WORD_W-1:0] y_o,
    output logic              ovf_o,
    output logic              unf_o
);
    logic                    carry;
    logic [FRAC_W-1:0]       frac;
    logic signed [EXT_W-1:0] e_adj;
    fp_word_t                res;

    assign carry = prod_i[PROD_W-1];
    assign frac  = carry ? prod_i[PROD_W-2 -: FRAC_W] : prod_i[PROD_W-3 -: FRAC_W];
    assign e_adj = $signed({2'b00, exp_a_i}) + $signed({2'b00, exp_b_i})
                 - EXT_W'(BIAS) + EXT_W'(carry);

    always_comb begin
        res.sign = sign_i;
        res.exp  = '0;
        res.frac = '0;
        ovf_o    = 1'b0;
        unf_o    = 1'b0;
        if (zero_in_i) begin
            res.exp = '0;
        end else if (e_adj >= EXT_W'(EXP_MAX)) begin
            ovf_o   = 1'b1;
            res.exp = '1;
        end else if (e_adj <= 0) begin
            unf_o   = 1'b1;
        end else begin
            res.exp  = e_adj[EXP_W-1:0];
            res.frac = frac;
        end
    end

    assign y_o = res;

    logic unused_low;
    assign unused_low = ^prod_i[PROD_W-3-FRAC_W:0];

    always_comb begin
        p_flags_excl_r6: assert (!(ovf_o && unf_o))
            else $error("overflow and underflow raised together");
        if (ovf_o) begin
            p_ovf_inf_r6: assert (y_o[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})
                else $error("overflow output is not infinity");
        end
        if (unf_o) begin
            p_unf_zero_r7: assert (y_o[WORD_W-2:0] == '0)
                else $error("underflow output is not zero");
        end
        if (zero_in_i) begin
            p_zero_in_r8: assert (!ovf_o && !unf_o && y_o[WORD_W-2:0] == '0)
                else $error("zero operand gave flags or nonzero result");
        end
        if (!zero_in_i && !ovf_o && !unf_o) begin
            p_exp_range_r3: assert (y_o[WORD_W-2 -: EXP_W] != '0 &&
                                    y_o[WORD_W-2 -: EXP_W] != '1)
                else $error("normal result exponent outside range");
        end
    end
endmodule

// File: rtl/fpm_mul_top.sv
module fpm_mul_top
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] y_o,
    output logic              ovf_o,
    output logic              unf_o
);
    fp_parts_t         pa, pb;
    logic [PROD_W-1:0] prod;

    fpm_unpack u_unp_a (.word_i(a_i), .parts_o(pa));
    fpm_unpack u_unp_b (.word_i(b_i), .parts_o(pb));

    fpm_booth_mult #(.W(SIG_W)) u_mult (
        .a_i (pa.sig),
        .b_i (pb.sig),
        .p_o (prod)
    );

    fpm_pack u_pack (
        .sign_i    (pa.sign ^ pb.sign),
        .exp_a_i   (pa.exp),
        .exp_b_i   (pb.exp),
        .zero_in_i (pa.is_zero | pb.is_zero),
        .prod_i    (prod),
        .y_o       (y_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    always_comb begin
        p_sign_r2: assert (y_o[WORD_W-1] == (a_i[WORD_W-1] ^ b_i[WORD_W-1]))
            else $error("result sign differs from operand sign xor");
    end
endmodule

// File: tb/fpm_mul_top_tb_top.sv
module fpm_mul_top_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] a, b, y;
    logic        ovf, unf;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    fpm_mul_top dut_i (.a_i(a), .b_i(b), .y_o(y), .ovf_o(ovf), .unf_o(unf));

    // Model: exact significand product, truncation, range handling.
    function automatic logic [33:0] model(input logic [31:0] x, input logic [31:0] z);
        logic [47:0] p;
        int          e;
        logic [22:0] f;
        logic        s;
        s = x[31] ^ z[31];
        if (x[30:23] == 0 || z[30:23] == 0) return {s, 31'd0, 2'b00};
        p = {24'd0, 1'b1, x[22:0]} * {24'd0, 1'b1, z[22:0]};
        e = int'(x[30:23]) + int'(z[30:23]) - 127;
        if (p[47]) begin e = e + 1; f = p[46:24]; end
        else f = p[45:23];
        if (e >= 255) return {s, 8'hFF, 23'd0, 2'b10};
        if (e <= 0)   return {s, 31'd0, 2'b01};
        return {s, e[7:0], f, 2'b00};
    endfunction

    task automatic check(input string req, input logic [31:0] x, input logic [31:0] z,
                         input logic [31:0] ey, input logic eo, input logic eu);
        @(posedge clk);
        a = x; b = z;
        @(negedge clk);
        checks++;
        if (y !== ey || ovf !== eo || unf !== eu) begin
            errors++;
            $display("FAIL %s a=%h b=%h got y=%h ovf=%b unf=%b expected y=%h ovf=%b unf=%b",
                     req, x, z, y, ovf, unf, ey, eo, eu);
        end
    endtask

    // {req, a, b, y, ovf, unf}
    localparam int NV = 14;
    localparam logic [101:0] VEC [NV] = '{
        {4'd1, 32'h3F800000, 32'h3F800000, 32'h3F800000, 2'b00}, // R1 1*1
        {4'd3, 32'h40000000, 32'h40400000, 32'h40C00000, 2'b00}, // R3 2*3
        {4'd4, 32'h3FC00000, 32'h3FC00000, 32'h40100000, 2'b00}, // R4 1.5*1.5 shift
        {4'd2, 32'hC0000000, 32'h3F000000, 32'hBF800000, 2'b00}, // R2 -2*0.5
        {4'd2, 32'h3FC00000, 32'hBFC00000, 32'hC0100000, 2'b00}, // R2 1.5*-1.5
        {4'd5, 32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 2'b00}, // R5 truncation
        {4'd6, 32'h7F000000, 32'h7F000000, 32'h7F800000, 2'b10}, // R6 far overflow
        {4'd6, 32'h7F000000, 32'h3F800000, 32'h7F000000, 2'b00}, // R6 edge 254 fits
        {4'd6, 32'h7F400000, 32'hBFC00000, 32'hFF800000, 2'b10}, // R6 carry to 255
        {4'd7, 32'h00800000, 32'h00800000, 32'h00000000, 2'b01}, // R7 far underflow
        {4'd7, 32'h00800000, 32'h3F000000, 32'h00000000, 2'b01}, // R7 edge 0
        {4'd7, 32'h00C00000, 32'h3F400000, 32'h00900000, 2'b00}, // R7 carry lifts 0 to 1
        {4'd8, 32'h00000000, 32'h3F800000, 32'h00000000, 2'b00}, // R8 zero operand
        {4'd8, 32'h7F000000, 32'h807FFFFF, 32'h80000000, 2'b00}  // R8 zero exp, no flag
    };

    initial begin
        a = '0; b = '0;
        // reset state: idle zero inputs give +0, no flags (R8)
        check("R8", 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [101:0] v;
            v = VEC[i];
            check($sformatf("R%0d", v[101:98]), v[97:66], v[65:34], v[33:2], v[1], v[0]);
        end

        // R9: extreme significand patterns
        check("R9", 32'h3FFFFFFF, 32'h3F800000, 32'h3FFFFFFF, 1'b0, 1'b0);
        check("R9", 32'h3FAAAAAA, 32'h3FD55555,
              model(32'h3FAAAAAA, 32'h3FD55555) >> 2, 1'b0, 1'b0);

        // R1 R9: random normal operands, including exponent corners
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] x, z;
            logic [33:0] m;
            x = $urandom; z = $urandom;
            x[30:23] = 8'(1 + ($urandom % 254));
            z[30:23] = 8'(1 + ($urandom % 254));
            if (n % 7 == 0) z[30:23] = 8'(254 - (n % 3));
            if (n % 11 == 0) z[30:23] = 8'(1 + (n % 3));
            m = model(x, z);
            check("R1", x, z, m[33:2], m[1], m[0]);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule